// File: doc/BRIEF.md
# Carry-Chained Frame Checksum Unit

This block forms an 8-bit checksum over a 256-slot link frame. Bytes arrive one per valid cycle, each tagged with its timeslot number. Every byte outside the frame alignment slot is added to the running sum. The carry out of each addition is fed into the next addition, and the carry out of the last addition is dropped.

When the alignment slot arrives, its byte is not summed. The finished sum of the frame that just ended is captured into a holding register, and the accumulator and carry are cleared for the new frame. On the transmit side, the held value is the byte that goes out in the checksum slot of the following frame. On the receive side, the same unit compares the byte received in that checksum slot with its own held value. It counts mismatches, but only while the link is in frame lock, and the count is reported as a high byte and a low byte.

Top module: `frame_csum_unit`

## Requirements
- R1: After reset, `csum_out`, `err_hi` and `err_lo` are all zero, and no mismatch is counted before the first alignment slot has been seen.
- R2: For each valid byte in a slot other than the alignment slot, the 9-bit result of sum + byte + carry gives the new 8-bit sum (bits 7:0) and the new carry (bit 8).
- R3: A valid byte in the alignment slot (slot 0) is not summed. On that cycle the finished sum is copied to `csum_out`, and the sum and carry both become zero, so the first byte of a frame sees no carry in.
- R4: `csum_out` changes only on a valid alignment-slot byte and keeps its value for the rest of the frame.
- R5: Cycles with `slot_vld` low change neither the sum, nor the carry, nor the count, whatever slot number or byte is presented.
- R6: A valid byte in the checksum slot (slot 16) that differs from `csum_out` adds one to the error count, provided `frame_locked` is high and an alignment slot has been seen since reset.
- R7: A checksum-slot byte equal to `csum_out` leaves the error count unchanged.
- R8: While `frame_locked` is low, the error count does not change.
- R9: The 16-bit error count saturates at 0xFFFF and does not wrap.
- R10: `err_hi` carries count bits 15:8 and `err_lo` carries bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 1 | A byte is present this cycle |
| slot_num | input | 8 | Timeslot number of the byte |
| slot_byte | input | 8 | Byte value |
| frame_locked | input | 1 | The receiver is in frame lock |
| csum_out | output | 8 | Held checksum of the previous frame |
| err_hi | output | 8 | Error count, high byte |
| err_lo | output | 8 | Error count, low byte |

## Verification
The carry chain is tried with four frame fills:
- All 0xFF keeps the carry set on almost every step.
- A linear ramp mixes carries.
- A scrambled fill varies the bytes across the frame.
- All zeros never produces a carry.

Together these separate a correct chain from a dropped carry, a wrapped carry and a missing clear at the frame boundary. The alignment byte is set to 0xA5, and idle cycles present slot 0 with the valid flag low, which shows whether the exclusion and the valid qualification work. The checksum-slot byte is sent matching, mismatching, before the first capture and while unlocked. A long run of mismatches then drives the counter across a byte boundary and into saturation.

// File: rtl/fcsum_pkg.sv
package fcsum_pkg;
  localparam int BYTE_W = 8;

  // one link of the carry chain: {carry_out, sum}
  function automatic logic [BYTE_W:0] csum_step(input logic [BYTE_W-1:0] acc,
                                                input logic [BYTE_W-1:0] b,
                                                input logic cin);
    return {1'b0, acc} + {1'b0, b} + {{BYTE_W{1'b0}}, cin};
  endfunction

  // saturating increment
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] top);
    return (v == top) ? v : v + 32'd1;
  endfunction
endpackage

// File: rtl/fcsum_accum.sv
module fcsum_accum
  import fcsum_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int SYNC_SLOT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] held,
  output logic              held_ok
);
  localparam logic [SLOT_W-1:0] SYNC_ID = SLOT_W'(SYNC_SLOT);

  logic [BYTE_W-1:0] acc;
  logic              cy;
  logic [BYTE_W:0]   nxt;
  logic              sync_ev;
  logic              add_ev;

  assign sync_ev = vld && (slot == SYNC_ID);
  assign add_ev  = vld && (slot != SYNC_ID);
  assign nxt     = csum_step(acc, din, cy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      cy      <= 1'b0;
      held    <= '0;
      held_ok <= 1'b0;
    end else if (sync_ev) begin
      held    <= acc;
      held_ok <= 1'b1;
      acc     <= '0;
      cy      <= 1'b0;
    end else if (add_ev) begin
      acc <= nxt[BYTE_W-1:0];
      cy  <= nxt[BYTE_W];
    end
  end

  // R3
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ev |=> (acc == '0) && !cy);
  // R3
  held_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ev |=> held == $past(acc));
  // R4
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ev |=> $stable(held));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(acc) && $stable(cy));
endmodule

// File: rtl/fcsum_err_cnt.sv
module fcsum_err_cnt
  import fcsum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (bump) cnt <= CNT_W'(sat_inc(32'(cnt), 32'(TOP)));
  end

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP) |=> (cnt == TOP));
  // R7
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(cnt));
  // R9
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> cnt >= $past(cnt));
endmodule

// File: rtl/frame_csum_unit.sv
module frame_csum_unit
  import fcsum_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int SYNC_SLOT = 0,
  parameter int CSUM_SLOT = 16,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_vld,
  input  logic [SLOT_W-1:0]    slot_num,
  input  logic [BYTE_W-1:0]    slot_byte,
  input  logic                 frame_locked,
  output logic [BYTE_W-1:0]    csum_out,
  output logic [CNT_W/2-1:0]   err_hi,
  output logic [CNT_W/2-1:0]   err_lo
);
  localparam int HALF = CNT_W / 2;
  localparam logic [SLOT_W-1:0] CSUM_ID = SLOT_W'(CSUM_SLOT);

  logic             held_ok;
  logic             csum_slot_ev;
  logic             mism_ev;
  logic [CNT_W-1:0] err_cnt;

  fcsum_accum #(.SLOT_W(SLOT_W), .SYNC_SLOT(SYNC_SLOT)) accum_i (
    .clk(clk), .rst_n(rst_n), .vld(slot_vld), .slot(slot_num),
    .din(slot_byte), .held(csum_out), .held_ok(held_ok)
  );

  assign csum_slot_ev = slot_vld && (slot_num == CSUM_ID);
  assign mism_ev      = csum_slot_ev && held_ok && frame_locked && (slot_byte != csum_out);

  fcsum_err_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .bump(mism_ev), .cnt(err_cnt)
  );

  assign err_hi = err_cnt[CNT_W-1:HALF];
  assign err_lo = err_cnt[HALF-1:0];

  // R8
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_locked |=> $stable(err_cnt));
  // R1
  no_ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held_ok |=> $stable(err_cnt));
endmodule

// File: tb/frame_csum_unit_tb_top.sv
module frame_csum_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_vld = 1'b0;
  logic [7:0] slot_num = '0;
  logic [7:0] slot_byte = '0;
  logic frame_locked = 1'b0;
  logic [7:0] csum_out, err_hi, err_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frame_csum_unit dut_i (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_num(slot_num),
    .slot_byte(slot_byte), .frame_locked(frame_locked),
    .csum_out(csum_out), .err_hi(err_hi), .err_lo(err_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_byte(input int pat, input int s);
    case (pat)
      0: return 8'hFF;
      1: return 8'(s * 7 + 3);
      2: return 8'((s * 37) ^ (s >> 1) ^ 8'h5C);
      default: return 8'h00;
    endcase
  endfunction

  function automatic int err_now();
    return {err_hi, err_lo};
  endfunction

  task automatic idle();
    @(negedge clk);
    slot_vld  = 1'b0;
    slot_num  = 8'd0;
    slot_byte = 8'h3C;
  endtask

  // drive slots 1..255; model sums them with its own carry handling
  task automatic run_body(input int pat, input logic [7:0] s16, input logic lock,
                          output logic [7:0] sum);
    int total = 0;
    int c = 0;
    for (int s = 1; s < 256; s++) begin
      logic [7:0] b = (s == 16) ? s16 : pat_byte(pat, s);
      if (pat == 1 && (s % 7) == 0) idle();   // R5 gaps showing slot 0 with valid low
      @(negedge clk);
      slot_vld = 1'b1; slot_num = 8'(s); slot_byte = b; frame_locked = lock;
      total = (total + b + c);
      c = total / 256;
      total = total % 256;
    end
    idle();
    sum = 8'(total);
  endtask

  // alignment slot: held value before (R4), captured after (R3)
  task automatic latch_check(input logic [7:0] old_v, input logic [7:0] exp_v, input string tag);
    chk({"R4 held across frame ", tag}, csum_out, old_v);
    @(negedge clk);
    slot_vld = 1'b1; slot_num = 8'd0; slot_byte = 8'hA5;
    idle();
    chk({"R2 R3 captured sum ", tag}, csum_out, exp_v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R1 csum_out reset", csum_out, 0);
    chk("R1 err reset", err_now(), 0);
  endtask

  task automatic t_frames();
    logic [7:0] sa, sb, sc, sd, se;
    run_body(0, 8'h77, 1'b1, sa);
    chk("R1 no count before first capture", err_now(), 0);
    latch_check(8'h00, sa, "all-FF");
    run_body(1, sa, 1'b1, sb);
    chk("R7 matching checksum not counted", err_now(), 0);
    chk("R5 idle slot-0 cycles ignored", csum_out, sa);
    latch_check(sa, sb, "ramp");
    run_body(2, sb ^ 8'h01, 1'b1, sc);
    chk("R6 mismatch counted", err_now(), 1);
    latch_check(sb, sc, "scrambled");
    run_body(3, sc ^ 8'h80, 1'b0, sd);
    chk("R8 unlocked mismatch ignored", err_now(), 1);
    latch_check(sc, sd, "zeros");
    run_body(0, sd, 1'b1, se);
    latch_check(sd, se, "all-FF again, no carry in");
  endtask

  task automatic t_saturate();
    logic [7:0] h = csum_out;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      slot_vld = 1'b1; slot_num = 8'd16; slot_byte = ~h; frame_locked = 1'b1;
    end
    idle();
    chk("R10 err_hi byte", err_hi, 8'h01);
    chk("R10 err_lo byte", err_lo, 8'h2D);
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk);
      slot_vld = 1'b1; slot_num = 8'd16; slot_byte = ~h; frame_locked = 1'b1;
    end
    idle();
    chk("R9 saturated count", err_now(), 16'hFFFF);
    chk("R4 held unchanged by slot-16 bytes", csum_out, h);
  endtask

  initial begin
    t_reset();
    t_frames();
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule